// File: doc/BRIEF.md
# Load/Store Alignment and Formatting Unit

This unit sits between an execute stage and a 64-bit data cache. It takes one memory access at a time and carries it to completion.

For a store, it turns the register value into cache lane data and byte enables. For a load, it turns the doublewords returned by the cache into a register value. It can byte-reverse the access, and for a load it can sign- or zero-extend the result. An access that straddles a doubleword boundary is split into two back-to-back cache requests, and the unit counts the acknowledgements for both before it finishes.

Update-form accesses also return the effective address, as a second write to the base register. While an access is in flight the unit raises a busy signal toward decode, so no new request is taken.

Byte lanes are little-endian within a doubleword: lane j holds the byte whose address has low three bits equal to j. Placement works by rotation, not shifting, so the bytes that belong to the second doubleword of a split access land in the low lanes. Byte reversal and rotation are folded into one multiplexer per byte.

Top module: `ldst_align`

## Requirements
- R1: After reset, `busy`, `dc_valid` and `wb_valid` are all low.
- R2: `req_size` encodes the access length as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. For each cache request, `dc_be` bit j is set exactly for the bytes of the access that fall in lane j of that request's doubleword, and `dc_addr` is the doubleword-aligned address.
- R3: A store writes byte k of `req_data` (k counted from the least significant byte) to address addr+k. When `req_rev` is set, it writes byte k to addr+n-1-k instead, where n is the access length. Bytes of `req_data` above n are never written.
- R4: An access whose last byte lies in the next doubleword issues two cache requests. The second request is for the following doubleword, with the enables of the overflowing bytes. Without a stall, the second request is presented in the cycle right after the first is accepted.
- R5: A request presented while `dc_stall` is high is presented again in the next cycle with the same address, enables and data. Stalls delay completion by one cycle each.
- R6: A load writes its result to `req_rd` with a one-cycle `wb_valid` pulse, in the cycle after its last acknowledgement. Counted from the cycle the request is accepted, this is 3 cycles for a single request and 4 cycles for a split one.
- R7: A load shorter than 8 bytes fills the bits above the loaded bytes with zero. When `req_sign` is set, it fills them with the top bit of the most significant loaded byte instead.
- R8: A load with `req_rev` set returns the loaded bytes in reversed order before extension.
- R9: With `req_upd` set, the unit makes a write of the zero-extended effective address to `req_ra`. For a load this comes in the cycle after the load result; for a store it comes one cycle after the store completes.
- R10: `busy` is high from the cycle after a request is accepted until the access finishes. A `req_valid` that arrives while `busy` is high is ignored.
- R11: For a split load, each byte of the result is taken from whichever of the two returned doublewords holds it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | New access offered (taken when `busy` is low) |
| req_load | input | 1 | 1 = load, 0 = store |
| req_addr | input | AW | Effective byte address |
| req_data | input | 64 | Store value, least significant byte first |
| req_size | input | 2 | Access length code |
| req_sign | input | 1 | Sign-extend load result |
| req_rev | input | 1 | Byte-reverse the access |
| req_upd | input | 1 | Write effective address back to base register |
| req_rd | input | 5 | Load destination register |
| req_ra | input | 5 | Base register for update |
| busy | output | 1 | Stall toward decode |
| dc_valid | output | 1 | Cache request valid |
| dc_load | output | 1 | Cache request is a read |
| dc_addr | output | AW | Doubleword-aligned cache address |
| dc_be | output | 8 | Lane enables |
| dc_data | output | 64 | Lane-aligned store data |
| dc_stall | input | 1 | Request in this cycle not accepted |
| dc_ack | input | 1 | Cache acknowledge (one per accepted request) |
| dc_rdata | input | 64 | Read data qualified by `dc_ack` |
| wb_valid | output | 1 | Register write strobe |
| wb_reg | output | 5 | Register index |
| wb_data | output | 64 | Register value |

## Verification
The assertions guard the cache handshake on every cycle. A stalled request must be held unchanged on the next cycle. A request is never issued while `busy` is low, and never issued with empty enables. A second request always targets the doubleword after the first. A writeback never coincides with an outstanding request.

Only the bench scenarios can show that the data is right: the bytes that land in memory for rotated and reversed stores, the merge of split loads, and sign and zero extension. The same holds for the cycle counts of results and updates under stalls, and for requests offered while busy being dropped.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ1 = 3'd1,
        ST_REQ2 = 3'd2,
        ST_WAIT = 3'd3,
        ST_UPD  = 3'd4
    } lsu_state_e;

endpackage

// File: rtl/ldst_be_gen.sv
module ldst_be_gen #(
    parameter int NB  = 8,
    parameter int OW  = 3,
    parameter int SZW = 2
) (
    input  logic [OW-1:0]  off,
    input  logic [SZW-1:0] size,
    output logic [NB-1:0]  be_lo,
    output logic [NB-1:0]  be_hi
);
    logic [2*NB-1:0] ones;
    logic [2*NB-1:0] span;
    int unsigned     nbytes;

    always_comb begin
        nbytes = 32'd1 << size;
        ones   = '0;
        for (int i = 0; i < NB; i++) begin
            ones[i] = (i < nbytes);
        end
        span  = ones << off;
        be_lo = span[NB-1:0];
        be_hi = span[2*NB-1:NB];
    end
endmodule

// File: rtl/ldst_lane_mux.sv
module ldst_lane_mux #(
    parameter int NB     = 8,
    parameter int OW     = 3,
    parameter int SZW    = 2,
    parameter bit TO_MEM = 1'b1
) (
    input  logic [8*NB-1:0] din,
    input  logic [OW-1:0]   off,
    input  logic [SZW-1:0]  size,
    input  logic            rev,
    output logic [8*NB-1:0] dout
);
    logic [OW-1:0] last_idx;

    always_comb last_idx = OW'((32'd1 << size) - 32'd1);

    for (genvar g = 0; g < NB; g++) begin : g_lane
        localparam logic [OW-1:0] POS = OW'(g);
        logic [OW-1:0] k;
        logic [OW-1:0] sel;
        logic [7:0]    pick;

        if (TO_MEM) begin : g_to_mem
            // lane g holds access byte (g - off); reversal mirrors it
            always_comb begin
                k   = POS - off;
                sel = rev ? (last_idx - k) : k;
            end
        end else begin : g_from_mem
            // result byte g comes from lane (off + possibly mirrored g)
            always_comb begin
                k   = rev ? (last_idx - POS) : POS;
                sel = off + k;
            end
        end

        always_comb begin
            pick = '0;
            for (int i = 0; i < NB; i++) begin
                if (sel == OW'(i)) pick = din[8*i +: 8];
            end
        end

        assign dout[8*g +: 8] = pick;
    end
endmodule

// File: rtl/ldst_extend.sv
module ldst_extend #(
    parameter int NB  = 8,
    parameter int SZW = 2
) (
    input  logic [8*NB-1:0] din,
    input  logic [SZW-1:0]  size,
    input  logic            sgn,
    output logic [8*NB-1:0] dout
);
    int unsigned nbytes;
    logic        top_bit;

    always_comb begin
        nbytes  = 32'd1 << size;
        top_bit = 1'b0;
        for (int g = 0; g < NB; g++) begin
            if (g == nbytes - 1) top_bit = din[8*g + 7];
        end
        for (int g = 0; g < NB; g++) begin
            dout[8*g +: 8] = (g < nbytes) ? din[8*g +: 8] : {8{sgn & top_bit}};
        end
    end
endmodule

// File: rtl/ldst_align.sv
module ldst_align
    import ldst_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 64,
    parameter int RW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_load,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic [1:0]    req_size,
    input  logic          req_sign,
    input  logic          req_rev,
    input  logic          req_upd,
    input  logic [RW-1:0] req_rd,
    input  logic [RW-1:0] req_ra,
    output logic          busy,
    output logic          dc_valid,
    output logic          dc_load,
    output logic [AW-1:0] dc_addr,
    output logic [DW/8-1:0] dc_be,
    output logic [DW-1:0] dc_data,
    input  logic          dc_stall,
    input  logic          dc_ack,
    input  logic [DW-1:0] dc_rdata,
    output logic          wb_valid,
    output logic [RW-1:0] wb_reg,
    output logic [DW-1:0] wb_data
);
    localparam int NB  = DW / 8;
    localparam int OW  = $clog2(NB);
    localparam int SZW = 2;

    typedef struct packed {
        lsu_state_e    st;
        logic          is_load;
        logic [AW-1:0] ea;
        logic [DW-1:0] sdata;
        logic [SZW-1:0] size;
        logic          sgn;
        logic          rev;
        logic          upd;
        logic [RW-1:0] rd;
        logic [RW-1:0] ra;
        logic [1:0]    acks;
        logic [DW-1:0] half0;
        logic          wb_v;
        logic [RW-1:0] wb_r;
        logic [DW-1:0] wb_d;
    } lsu_regs_t;

    lsu_regs_t r_d, r_q;

    logic [OW-1:0] off_w;
    logic [NB-1:0] be_lo_w, be_hi_w;
    logic          cross_w;
    logic [DW-1:0] st_lanes_w;
    logic [DW-1:0] merged_w;
    logic [DW-1:0] ordered_w;
    logic [DW-1:0] ld_result_w;
    logic [AW-1:0] dw0_w, dw1_w;
    logic [1:0]    need_w, acks_now_w;

    assign off_w = r_q.ea[OW-1:0];

    ldst_be_gen #(.NB(NB), .OW(OW), .SZW(SZW)) i_be (
        .off   (off_w),
        .size  (r_q.size),
        .be_lo (be_lo_w),
        .be_hi (be_hi_w)
    );

    ldst_lane_mux #(.NB(NB), .OW(OW), .SZW(SZW), .TO_MEM(1'b1)) i_st_mux (
        .din  (r_q.sdata),
        .off  (off_w),
        .size (r_q.size),
        .rev  (r_q.rev),
        .dout (st_lanes_w)
    );

    always_comb begin
        for (int j = 0; j < NB; j++) begin
            merged_w[8*j +: 8] = (cross_w && !be_hi_w[j]) ? r_q.half0[8*j +: 8]
                                                           : dc_rdata[8*j +: 8];
        end
    end

    ldst_lane_mux #(.NB(NB), .OW(OW), .SZW(SZW), .TO_MEM(1'b0)) i_ld_mux (
        .din  (merged_w),
        .off  (off_w),
        .size (r_q.size),
        .rev  (r_q.rev),
        .dout (ordered_w)
    );

    ldst_extend #(.NB(NB), .SZW(SZW)) i_ext (
        .din  (ordered_w),
        .size (r_q.size),
        .sgn  (r_q.sgn),
        .dout (ld_result_w)
    );

    assign cross_w    = |be_hi_w;
    assign dw0_w      = {r_q.ea[AW-1:OW], {OW{1'b0}}};
    assign dw1_w      = dw0_w + AW'(NB);
    assign need_w     = cross_w ? 2'd2 : 2'd1;
    assign acks_now_w = r_q.acks + {1'b0, dc_ack};

    always_comb begin
        r_d      = r_q;
        r_d.wb_v = 1'b0;
        dc_valid = 1'b0;
        dc_addr  = dw0_w;
        dc_be    = be_lo_w;

        if (r_q.st == ST_REQ1 || r_q.st == ST_REQ2 || r_q.st == ST_WAIT) begin
            if (dc_ack) begin
                if (r_q.acks == 2'd0) r_d.half0 = dc_rdata;
                r_d.acks = acks_now_w;
            end
        end

        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st      = ST_REQ1;
                    r_d.is_load = req_load;
                    r_d.ea      = req_addr;
                    r_d.sdata   = req_data;
                    r_d.size    = req_size;
                    r_d.sgn     = req_sign;
                    r_d.rev     = req_rev;
                    r_d.upd     = req_upd;
                    r_d.rd      = req_rd;
                    r_d.ra      = req_ra;
                    r_d.acks    = 2'd0;
                end
            end
            ST_REQ1: begin
                dc_valid = 1'b1;
                if (!dc_stall) r_d.st = cross_w ? ST_REQ2 : ST_WAIT;
            end
            ST_REQ2: begin
                dc_valid = 1'b1;
                dc_addr  = dw1_w;
                dc_be    = be_hi_w;
                if (!dc_stall) r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (acks_now_w == need_w) begin
                    r_d.wb_v = r_q.is_load;
                    r_d.wb_r = r_q.rd;
                    r_d.wb_d = ld_result_w;
                    r_d.acks = 2'd0;
                    r_d.st   = r_q.upd ? ST_UPD : ST_IDLE;
                end
            end
            ST_UPD: begin
                r_d.wb_v = 1'b1;
                r_d.wb_r = r_q.ra;
                r_d.wb_d = DW'(r_q.ea);
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy     = (r_q.st != ST_IDLE);
    assign dc_load  = r_q.is_load;
    assign dc_data  = st_lanes_w;
    assign wb_valid = r_q.wb_v;
    assign wb_reg   = r_q.wb_r;
    assign wb_data  = r_q.wb_d;

    a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_valid && dc_stall) |=> (dc_valid && $stable(dc_addr) && $stable(dc_be) && $stable(dc_data)));

    a_r10_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        dc_valid |-> busy);

    a_r2_be_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        dc_valid |-> (dc_be != '0));

    a_r4_next_dword: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_REQ2 && $past(r_q.st) == ST_REQ1) |-> (dc_addr == $past(dc_addr) + AW'(NB)));

    a_r6_wb_idle_port: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !dc_valid);

    a_r4_ack_bound: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.acks <= 2'd1);
endmodule

// File: tb/test_ldst_align.sv
module test_ldst_align;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_load = 1'b0, req_sign = 1'b0, req_rev = 1'b0, req_upd = 1'b0;
    logic [31:0] req_addr = '0;
    logic [63:0] req_data = '0;
    logic [1:0]  req_size = '0;
    logic [4:0]  req_rd = '0, req_ra = '0;
    logic        busy, dc_valid, dc_load, wb_valid;
    logic [31:0] dc_addr;
    logic [7:0]  dc_be;
    logic [63:0] dc_data, wb_data;
    logic [4:0]  wb_reg;
    logic        dc_stall = 1'b0;
    logic        dc_ack;
    logic [63:0] dc_rdata;

    always #2 clk = ~clk;

    ldst_align i_ldst_align (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_load(req_load),
        .req_addr(req_addr), .req_data(req_data), .req_size(req_size),
        .req_sign(req_sign), .req_rev(req_rev), .req_upd(req_upd),
        .req_rd(req_rd), .req_ra(req_ra), .busy(busy), .dc_valid(dc_valid),
        .dc_load(dc_load), .dc_addr(dc_addr), .dc_be(dc_be), .dc_data(dc_data),
        .dc_stall(dc_stall), .dc_ack(dc_ack), .dc_rdata(dc_rdata),
        .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data)
    );

    int n_checks = 0, n_fail = 0, cyc = 0;
    logic [7:0] mem  [0:255];
    logic [7:0] gmem [0:255];
    logic [31:0] log_addr [0:63];
    logic [7:0]  log_be   [0:63];
    int          log_cyc  [0:63];
    int          log_n = 0;
    logic [68:0] exp_q [$];
    string       tag_q [$];
    int          first_wb_cyc = 0;
    bit          got_first = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // cache model: one-cycle acknowledge after acceptance
    always @(posedge clk) begin
        dc_ack <= 1'b0;
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) & 255);
        end else if (dc_valid && !dc_stall) begin
            logic [63:0] rd;
            for (int j = 0; j < 8; j++) begin
                rd[8*j +: 8] = mem[(dc_addr + j) & 255];
                if (!dc_load && dc_be[j]) mem[(dc_addr + j) & 255] = dc_data[8*j +: 8];
            end
            dc_rdata <= rd;
            dc_ack   <= 1'b1;
            log_addr[log_n % 64] = dc_addr;
            log_be[log_n % 64]   = dc_be;
            log_cyc[log_n % 64]  = cyc;
            log_n++;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && wb_valid) begin
            if (!got_first) begin
                got_first    = 1'b1;
                first_wb_cyc = cyc;
            end
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected writeback", {59'd0, wb_reg}, 64'd0);
            end else begin
                logic [68:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(wb_reg == e[68:64], {t, " reg"}, {59'd0, wb_reg}, {59'd0, e[68:64]});
                check(wb_data == e[63:0], {t, " data"}, wb_data, e[63:0]);
            end
        end
    end

    always @(posedge clk) begin
        if (cyc == 60000) begin
            n_checks++;
            n_fail++;
            $display("FAIL R6 watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", n_checks, n_fail);
            $finish;
        end
    end

    function automatic logic [63:0] exp_load(logic [31:0] a, int n, bit sg, bit rv);
        logic [63:0] v = '0;
        for (int k = 0; k < n; k++) begin
            int idx = rv ? n - 1 - k : k;
            v[8*k +: 8] = gmem[(a + idx) & 255];
        end
        if (sg && n < 8 && v[8*n-1]) v = v | (~64'd0 << (8*n));
        return v;
    endfunction

    function automatic int mem_diff();
        int d = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== gmem[i]) d++;
        return d;
    endfunction

    int t_drive = 0;
    int lbase = 0;

    task automatic drive(input bit ld, input logic [31:0] a, input logic [63:0] d, input logic [1:0] sz,
                         input bit sg, input bit rv, input bit up, input logic [4:0] rd, input logic [4:0] ra,
                         input string tag);
        int n = 1 << sz;
        if (ld) begin
            exp_q.push_back({rd, exp_load(a, n, sg, rv)});
            tag_q.push_back(tag);
        end else begin
            for (int k = 0; k < n; k++) begin
                int idx = rv ? n - 1 - k : k;
                gmem[(a + idx) & 255] = d[8*k +: 8];
            end
        end
        if (up) begin
            exp_q.push_back({ra, 32'd0, a});
            tag_q.push_back("R9 update");
        end
        @(negedge clk);
        while (busy) @(negedge clk);
        req_load = ld; req_addr = a; req_data = d; req_size = sz;
        req_sign = sg; req_rev = rv; req_upd = up; req_rd = rd; req_ra = ra;
        req_valid = 1'b1;
        got_first = 1'b0;
        t_drive = cyc;
        lbase = log_n;
    endtask

    task automatic finish_op();
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_op(input bit ld, input logic [31:0] a, input logic [63:0] d, input logic [1:0] sz,
                         input bit sg, input bit rv, input bit up, input logic [4:0] rd, input logic [4:0] ra,
                         input string tag);
        drive(ld, a, d, sz, sg, rv, up, rd, ra, tag);
        finish_op();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) gmem[i] = 8'((i * 37 + 11) & 255);
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1 busy", {63'd0, busy}, 64'd0);
        check(dc_valid == 1'b0, "R1 dc_valid", {63'd0, dc_valid}, 64'd0);
        check(wb_valid == 1'b0, "R1 wb_valid", {63'd0, wb_valid}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R6 aligned 8-byte load, latency 3
        do_op(1, 32'h10, 0, 2'd3, 0, 0, 0, 5'd3, 5'd0, "R6 aligned load");
        check(first_wb_cyc - t_drive == 3, "R6 latency single", 64'(first_wb_cyc - t_drive), 64'd3);

        // R2/R3 4-byte store in one dword
        do_op(0, 32'h22, 64'hDEADBEEF_11223344, 2'd2, 0, 0, 0, 5'd0, 5'd0, "R3");
        check(log_be[lbase % 64] == 8'h3C, "R2 be single", {56'd0, log_be[lbase % 64]}, 64'h3C);
        check(log_addr[lbase % 64] == 32'h20, "R2 dword addr", {32'd0, log_addr[lbase % 64]}, 64'h20);
        check(mem_diff() == 0, "R3 store bytes", 64'(mem_diff()), 64'd0);

        // R3 reversed 2-byte store
        do_op(0, 32'h31, 64'h5566_7788_99AA_BBCC, 2'd1, 0, 1, 0, 5'd0, 5'd0, "R3");
        check(mem_diff() == 0, "R3 reversed store", 64'(mem_diff()), 64'd0);

        // R4 split 8-byte store
        do_op(0, 32'h45, 64'h0102030405060708, 2'd3, 0, 0, 0, 5'd0, 5'd0, "R4");
        check(log_n - lbase == 2, "R4 request count", 64'(log_n - lbase), 64'd2);
        check(log_addr[(lbase + 1) % 64] == 32'h48, "R4 second addr", {32'd0, log_addr[(lbase + 1) % 64]}, 64'h48);
        check(log_be[lbase % 64] == 8'hE0, "R4 first be", {56'd0, log_be[lbase % 64]}, 64'hE0);
        check(log_be[(lbase + 1) % 64] == 8'h1F, "R4 second be", {56'd0, log_be[(lbase + 1) % 64]}, 64'h1F);
        check(log_cyc[(lbase + 1) % 64] - log_cyc[lbase % 64] == 1, "R4 back to back",
              64'(log_cyc[(lbase + 1) % 64] - log_cyc[lbase % 64]), 64'd1);
        check(mem_diff() == 0, "R4 split store bytes", 64'(mem_diff()), 64'd0);

        // R11/R7 split signed 4-byte load, latency 4
        do_op(1, 32'h4E, 0, 2'd2, 1, 0, 0, 5'd4, 5'd0, "R11 split load");
        check(first_wb_cyc - t_drive == 4, "R6 latency split", 64'(first_wb_cyc - t_drive), 64'd4);

        // R7 byte extension
        do_op(0, 32'h60, 64'h9C, 2'd0, 0, 0, 0, 5'd0, 5'd0, "R3");
        do_op(1, 32'h60, 0, 2'd0, 1, 0, 0, 5'd7, 5'd0, "R7 sign ext");
        do_op(1, 32'h60, 0, 2'd0, 0, 0, 0, 5'd8, 5'd0, "R7 zero ext");
        do_op(0, 32'h62, 64'h8123, 2'd1, 0, 0, 0, 5'd0, 5'd0, "R3");
        do_op(1, 32'h62, 0, 2'd1, 1, 0, 0, 5'd9, 5'd0, "R7 half sign");

        // R8 reversed loads, including a split one
        do_op(1, 32'h62, 0, 2'd1, 0, 1, 0, 5'd10, 5'd0, "R8 rev half");
        do_op(1, 32'h43, 0, 2'd3, 0, 1, 0, 5'd11, 5'd0, "R8 rev split");
        do_op(1, 32'h3D, 0, 2'd2, 0, 1, 1, 5'd12, 5'd13, "R8 rev split word");

        // R9 update forms
        do_op(1, 32'h70, 0, 2'd2, 0, 0, 1, 5'd5, 5'd6, "R9 load");
        check(first_wb_cyc - t_drive == 3, "R9 load result first", 64'(first_wb_cyc - t_drive), 64'd3);
        do_op(0, 32'h84, 64'hCAFE, 2'd1, 0, 0, 1, 5'd0, 5'd7, "R9 store");
        check(first_wb_cyc - t_drive == 4, "R9 store update timing", 64'(first_wb_cyc - t_drive), 64'd4);
        check(mem_diff() == 0, "R9 store bytes", 64'(mem_diff()), 64'd0);

        // R5 stalls on both halves of a split load
        drive(1, 32'h5B, 0, 2'd3, 0, 0, 0, 5'd14, 5'd0, "R5 stalled load");
        dc_stall = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk); dc_stall = 1'b0;
        @(negedge clk); dc_stall = 1'b1;
        @(negedge clk); dc_stall = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        check(first_wb_cyc - t_drive == 7, "R5 stall latency", 64'(first_wb_cyc - t_drive), 64'd7);
        check(log_n - lbase == 2, "R5 accepted count", 64'(log_n - lbase), 64'd2);
        check(log_cyc[(lbase + 1) % 64] - log_cyc[lbase % 64] == 2, "R5 second delayed",
              64'(log_cyc[(lbase + 1) % 64] - log_cyc[lbase % 64]), 64'd2);

        // R10 requests while busy are ignored
        drive(1, 32'h18, 0, 2'd3, 0, 0, 0, 5'd15, 5'd0, "R10 load");
        @(negedge clk);
        check(busy == 1'b1, "R10 busy in flight", {63'd0, busy}, 64'd1);
        req_load = 1'b0; req_addr = 32'h90; req_data = 64'hFFFF_FFFF; req_size = 2'd2;
        req_upd = 1'b1; req_ra = 5'd20;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
        check(mem_diff() == 0, "R10 ignored store", 64'(mem_diff()), 64'd0);
        check(log_n - lbase == 1, "R10 request count", 64'(log_n - lbase), 64'd1);
        check(exp_q.size() == 0, "R10 scoreboard drained", 64'(exp_q.size()), 64'd0);

        $display("  test done: total=%0d bad=%0d", n_checks, n_fail);
        $finish;
    end
endmodule